// File: doc/BRIEF.md
# Receive Queue with Character Timeout

This block holds received serial characters between a deserializer and the software that reads them. It works in two modes. In queued mode, up to sixteen characters are buffered in arrival order. A programmable fill threshold raises a flag once enough characters are waiting. A timer raises a pending flag when characters have been sitting unread for four character times. In single-character mode, one holding register keeps the most recent character, and a character that arrives before the previous one was read is flagged as lost.

Arriving characters come from a valid strobe with a byte. A line break is reported by a separate strobe, and it enters the queue as a zero byte marked by a break flag. A read strobe takes the oldest character. A second strobe, tied to a read of the line status, clears the sticky lost-data and break flags. A control write selects the mode, flushes the queue and picks the threshold. A one-cycle tick marks each elapsed character time.

Top module: `rxq_timeout_buffer`

## Requirements
- R1: After synchronous reset the block is in single-character mode with threshold code 0, count 0, and data_ready, overrun, brk_flag, tmo_pend and rd_data all 0.
- R2: In queued mode, characters are read back in arrival order and count follows every accepted arrival and every read. data_ready is 1 exactly when count is nonzero.
- R3: In queued mode, a character that arrives while count equals DEPTH is dropped, the stored characters are kept, and overrun is set. count never exceeds DEPTH.
- R4: In single-character mode, an arrival stores the byte and sets data_ready. If data_ready is already set and no read happens in the same cycle, overrun is set and the new byte replaces the held one. count stays 0.
- R5: A break strobe acts as an arrival of byte 0x00 and sets both brk_flag and data_ready.
- R6: In queued mode, tmo_pend is set on the fourth char_tick after the last arrival or read, provided the queue is not empty. Any arrival or read restarts the count, and an empty queue never shows tmo_pend.
- R7: A read clears tmo_pend. A read that empties the queue clears data_ready and brk_flag. A read that leaves characters behind keeps brk_flag.
- R8: A read of the empty queue returns 0x00 on rd_data.
- R9: A control write with ctl_flush=1, or with ctl_fifo_on different from the current mode, empties the queue and clears data_ready, brk_flag and tmo_pend. overrun is not changed by a flush.
- R10: ctl_trig selects the threshold: 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14. In queued mode trig_hit is 1 when count is at least the threshold. In single-character mode trig_hit equals data_ready.
- R11: lsr_rd clears overrun and brk_flag. A new overrun or break in the same cycle wins over the clear.
- R12: In a cycle with ctl_wr=1, the arrival, break, read and lsr_rd strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received character is present on rx_byte |
| rx_byte | input | W | Received character |
| brk_evt | input | 1 | Line break detected |
| rd_stb | input | 1 | Read the oldest character |
| lsr_rd | input | 1 | Line status read; clears overrun and break |
| ctl_wr | input | 1 | Control write strobe |
| ctl_fifo_on | input | 1 | 1 selects queued mode, 0 single-character mode |
| ctl_flush | input | 1 | Empty the receive queue |
| ctl_trig | input | 2 | Threshold code |
| char_tick | input | 1 | One-cycle pulse per character time |
| rd_data | output | W | Character returned by the last read |
| count | output | clog2(DEPTH)+1 | Characters held in the queue |
| data_ready | output | 1 | A character is waiting |
| overrun | output | 1 | A character was lost |
| brk_flag | output | 1 | A break was received |
| trig_hit | output | 1 | Threshold reached |
| tmo_pend | output | 1 | Character timeout pending |

## Verification
On every cycle, the assertions check these rules:
- data_ready agrees with count in queued mode.
- Count stays within bounds.
- A full queue keeps its contents and flags the loss.
- A timer restart or an empty queue never lets the timeout flag rise.
- A flush, a break or a status read leaves the flags in their required state.

Only the bench scenarios can show the rest:
- The arrival order of the data.
- The threshold response at all four codes, swept from empty to full.
- The exact fourth-tick timing of the timeout.
- The value returned by a read of the empty queue.
- Which inputs are ignored during a control write.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [1:0] {
    TRIG_1  = 2'd0,
    TRIG_4  = 2'd1,
    TRIG_8  = 2'd2,
    TRIG_14 = 2'd3
  } rxq_trig_e;

  function automatic logic [4:0] trig_bytes(input rxq_trig_e sel);
    case (sel)
      TRIG_1:  trig_bytes = 5'd1;
      TRIG_4:  trig_bytes = 5'd4;
      TRIG_8:  trig_bytes = 5'd8;
      default: trig_bytes = 5'd14;
    endcase
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic                     wr_en,
  input  logic [W-1:0]             wr_data,
  input  logic                     rd_en,
  output logic [W-1:0]             head,
  output logic [$clog2(DEPTH):0]   count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  // distributed memory: write port without reset, asynchronous head read
  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  assign head = mem[rp];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_en) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (rd_en) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + CW'(wr_en) - CW'(rd_en);
    end
  end

  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  p_no_push_full_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> count < CW'(DEPTH));
  p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> count != '0);
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
  parameter int TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic restart,
  input  logic armed,
  input  logic drop,
  output logic pend
);
  localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICKS - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (restart)                 cnt <= '0;
      else if (tick && cnt != LAST) cnt <= cnt + 1'b1;

      if (drop)                                          pend <= 1'b0;
      else if (tick && !restart && armed && cnt == LAST) pend <= 1'b1;
    end
  end

  p_restart_no_fire_r6: assert property (@(posedge clk) disable iff (rst)
    restart |=> !$rose(pend));
  p_fire_needs_data_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(armed));
endmodule

// File: rtl/rxq_timeout_buffer.sv
module rxq_timeout_buffer
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  parameter int TICKS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rx_valid,
  input  logic [W-1:0]           rx_byte,
  input  logic                   brk_evt,
  input  logic                   rd_stb,
  input  logic                   lsr_rd,
  input  logic                   ctl_wr,
  input  logic                   ctl_fifo_on,
  input  logic                   ctl_flush,
  input  logic [1:0]             ctl_trig,
  input  logic                   char_tick,
  output logic [W-1:0]           rd_data,
  output logic [$clog2(DEPTH):0] count,
  output logic                   data_ready,
  output logic                   overrun,
  output logic                   brk_flag,
  output logic                   trig_hit,
  output logic                   tmo_pend
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic      fifo_on;
  rxq_trig_e trig_sel;
  logic [W-1:0] hold, head, in_byte;
  logic flush, arrive, rd_go, full, empty, pop, wr;
  logic [CW-1:0] nxt_cnt;

  // a control write owns its cycle; the other strobes are ignored (R12)
  assign flush   = ctl_wr && (ctl_flush || (ctl_fifo_on != fifo_on));
  assign arrive  = !ctl_wr && (rx_valid || brk_evt);
  assign rd_go   = !ctl_wr && rd_stb;
  assign in_byte = brk_evt ? '0 : rx_byte;
  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign pop     = fifo_on && rd_go && !empty;
  assign wr      = fifo_on && arrive && !full;
  assign nxt_cnt = count + CW'(wr) - CW'(pop);

  rxq_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(wr), .wr_data(in_byte), .rd_en(pop),
    .head(head), .count(count)
  );

  rxq_timer #(.TICKS(TICKS)) u_timer (
    .clk(clk), .rst(rst), .tick(char_tick),
    .restart((fifo_on && arrive) || pop || flush),
    .armed(!empty), .drop(rd_go || flush), .pend(tmo_pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_on    <= 1'b0;
      trig_sel   <= TRIG_1;
      hold       <= '0;
      rd_data    <= '0;
      data_ready <= 1'b0;
      overrun    <= 1'b0;
      brk_flag   <= 1'b0;
    end else if (ctl_wr) begin
      fifo_on  <= ctl_fifo_on;
      trig_sel <= rxq_trig_e'(ctl_trig);
      if (flush) begin
        data_ready <= 1'b0;
        brk_flag   <= 1'b0;
      end
    end else begin
      if (rd_go) rd_data <= fifo_on ? (empty ? '0 : head) : hold;
      if (fifo_on) begin
        data_ready <= (nxt_cnt != '0);
        if (arrive && full) overrun <= 1'b1;
        else if (lsr_rd)    overrun <= 1'b0;
        if (brk_evt)                               brk_flag <= 1'b1;
        else if ((pop && nxt_cnt == '0) || lsr_rd) brk_flag <= 1'b0;
      end else begin
        if (arrive) begin
          hold       <= in_byte;
          data_ready <= 1'b1;
        end else if (rd_go) begin
          data_ready <= 1'b0;
        end
        if (arrive && data_ready && !rd_go) overrun <= 1'b1;
        else if (lsr_rd)                    overrun <= 1'b0;
        if (brk_evt)              brk_flag <= 1'b1;
        else if (rd_go || lsr_rd) brk_flag <= 1'b0;
      end
    end
  end

  assign trig_hit = fifo_on ? (count >= CW'(trig_bytes(trig_sel))) : data_ready;

  p_dr_tracks_count_r2: assert property (@(posedge clk) disable iff (rst)
    fifo_on |-> data_ready == (count != '0));
  p_full_keeps_r3: assert property (@(posedge clk) disable iff (rst)
    (fifo_on && full && rx_valid && !ctl_wr && !rd_stb) |=> overrun && count == CW'(DEPTH));
  p_hold_overrun_r4: assert property (@(posedge clk) disable iff (rst)
    (!fifo_on && data_ready && rx_valid && !ctl_wr && !rd_stb) |=> overrun && data_ready);
  p_break_sets_r5: assert property (@(posedge clk) disable iff (rst)
    (brk_evt && !ctl_wr) |=> brk_flag && data_ready);
  p_empty_no_tmo_r6: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |-> !tmo_pend);
  p_read_drops_tmo_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !ctl_wr) |=> !tmo_pend);
  p_flush_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> count == '0 && !data_ready && !brk_flag && !tmo_pend);
  p_lsr_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && !ctl_wr && !rx_valid && !brk_evt) |=> !overrun && !brk_flag);
endmodule

// File: tb/rxq_timeout_buffer_test.sv
`timescale 1ns/1ps
module rxq_timeout_buffer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 0, brk_evt = 0, rd_stb = 0, lsr_rd = 0, ctl_wr = 0;
  logic ctl_fifo_on = 0, ctl_flush = 0, char_tick = 0;
  logic [1:0] ctl_trig = 0;
  logic [7:0] rx_byte = 0;
  logic [7:0] rd_data;
  logic [4:0] count;
  logic data_ready, overrun, brk_flag, trig_hit, tmo_pend;
  int vectors = 0;
  int errs = 0;

  always #10 clk = ~clk;

  rxq_timeout_buffer uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte), .brk_evt(brk_evt),
    .rd_stb(rd_stb), .lsr_rd(lsr_rd), .ctl_wr(ctl_wr), .ctl_fifo_on(ctl_fifo_on),
    .ctl_flush(ctl_flush), .ctl_trig(ctl_trig), .char_tick(char_tick),
    .rd_data(rd_data), .count(count), .data_ready(data_ready), .overrun(overrun),
    .brk_flag(brk_flag), .trig_hit(trig_hit), .tmo_pend(tmo_pend)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    rx_valid = 0; brk_evt = 0; rd_stb = 0; lsr_rd = 0; ctl_wr = 0; char_tick = 0;
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid = 1; rx_byte = b; step();
  endtask
  task automatic rd();    rd_stb = 1;    step(); endtask
  task automatic lsr();   lsr_rd = 1;    step(); endtask
  task automatic brk();   brk_evt = 1;   step(); endtask
  task automatic tick();  char_tick = 1; step(); endtask
  task automatic ctrl(input logic on, input logic fl, input logic [1:0] tr);
    ctl_wr = 1; ctl_fifo_on = on; ctl_flush = fl; ctl_trig = tr; step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 data_ready", data_ready, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 brk_flag", brk_flag, 0);
    chk("R1 tmo_pend", tmo_pend, 0);
    chk("R1 rd_data", rd_data, 0);

    // R4 single-character mode
    push(8'hA5);
    chk("R4 dr", data_ready, 1);
    chk("R10 trig equals dr", trig_hit, 1);
    push(8'h3C);
    chk("R4 overrun", overrun, 1);
    chk("R4 count stays 0", count, 0);
    rd();
    chk("R4 newest byte kept", rd_data, 8'h3C);
    chk("R4 dr cleared", data_ready, 0);
    chk("R10 trig after read", trig_hit, 0);
    lsr();
    chk("R11 overrun cleared", overrun, 0);
    push(8'h11);
    rx_valid = 1; rx_byte = 8'h22; lsr_rd = 1; step();
    chk("R11 set wins over clear", overrun, 1);
    lsr();
    rd();

    // R2 R3 R8 R9 R10 sweep of all threshold codes from empty to full
    for (int lv = 0; lv < 4; lv++) begin
      int lvb;
      lvb = (lv == 0) ? 1 : (lv == 1) ? 4 : (lv == 2) ? 8 : 14;
      ctrl(1, 1, lv[1:0]);
      chk("R9 flushed", count, 0);
      for (int k = 1; k <= 16; k++) begin
        push(8'(lv * 16 + k));
        chk("R2 count", count, k);
        chk("R10 trig_hit", trig_hit, (k >= lvb) ? 1 : 0);
        chk("R2 dr", data_ready, 1);
      end
      chk("R3 no overrun yet", overrun, 0);
      push(8'hEE);
      chk("R3 overrun", overrun, 1);
      chk("R3 count held", count, 16);
      if (lv == 3) begin
        ctrl(1, 1, 2'd3);
        chk("R9 count", count, 0);
        chk("R9 dr", data_ready, 0);
        chk("R9 overrun untouched", overrun, 1);
        chk("R10 trig empty", trig_hit, 0);
      end else begin
        for (int k = 1; k <= 16; k++) begin
          rd();
          chk("R2 order", rd_data, lv * 16 + k);
          chk("R7 dr after read", data_ready, (k < 16) ? 1 : 0);
        end
        rd();
        chk("R8 empty read", rd_data, 0);
      end
      lsr();
      chk("R11 overrun clear", overrun, 0);
    end

    // R5 R7 break handling
    ctrl(1, 1, 2'd0);
    brk();
    chk("R5 count", count, 1);
    chk("R5 brk", brk_flag, 1);
    chk("R5 dr", data_ready, 1);
    push(8'h77);
    rd();
    chk("R5 zero byte", rd_data, 0);
    chk("R7 brk kept while data", brk_flag, 1);
    lsr();
    chk("R11 brk cleared", brk_flag, 0);
    brk();
    rd();
    chk("R2 second byte", rd_data, 8'h77);
    chk("R7 brk kept", brk_flag, 1);
    rd();
    chk("R7 brk cleared on empty", brk_flag, 0);
    chk("R7 dr cleared on empty", data_ready, 0);

    // R6 R7 timeout
    push(8'h01);
    tick(); tick(); tick();
    chk("R6 three ticks", tmo_pend, 0);
    tick();
    chk("R6 fourth tick", tmo_pend, 1);
    push(8'h02);
    chk("R6 pend persists", tmo_pend, 1);
    rd();
    chk("R7 read clears pend", tmo_pend, 0);
    tick(); tick(); tick();
    push(8'h03);
    tick(); tick(); tick();
    chk("R6 restart by arrival", tmo_pend, 0);
    tick();
    chk("R6 fires after restart", tmo_pend, 1);
    rd();
    tick(); tick(); tick();
    chk("R6 restart by read", tmo_pend, 0);
    tick();
    chk("R6 fires after read", tmo_pend, 1);
    rd();
    chk("R7 empty", count, 0);
    for (int i = 0; i < 8; i++) tick();
    chk("R6 empty never fires", tmo_pend, 0);

    // R12 strobes ignored during control write
    push(8'h44); push(8'h55);
    ctl_wr = 1; ctl_fifo_on = 1; ctl_flush = 0; ctl_trig = 2'd1;
    rx_valid = 1; rx_byte = 8'h66; rd_stb = 1; brk_evt = 1; step();
    chk("R12 count", count, 2);
    chk("R12 brk", brk_flag, 0);
    chk("R10 trig code 1 with 2", trig_hit, 0);

    // R9 mode toggle forces flush
    ctrl(0, 0, 2'd0);
    chk("R9 toggle count", count, 0);
    chk("R9 toggle dr", data_ready, 0);
    push(8'h5A);
    rd();
    chk("R4 single mode read", rd_data, 8'h5A);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule